// File: doc/BRIEF.md
# Edge-Latching Interrupt Controller

This block gathers four single-cycle event lines and turns them into one level interrupt request for a host processor. The four lines are the trigger event and the end-of-acquisition event of two acquisition slots. The block records every rising edge on an event line in a pending register. It raises `irq_o` while any pending bit is also enabled in the mask.

Software uses a pipelined slave port with a 2-bit word address. The address is the byte address with its two low bits dropped. Behind the port are four 32-bit words:

| Word | Access | Effect |
|------|--------|--------|
| 0 | write | Turns sources off (clears mask bits). |
| 1 | write | Turns sources on (sets mask bits). |
| 2 | read | The current mask. |
| 3 | read, write-one-to-clear | The pending events. |

There is no data stream through the block. Every pin is a plain control or status signal. The slave never applies back-pressure: stall stays low, and every strobed cycle gets an acknowledge on the next cycle.

Top module: `irq_hub`

## Requirements
- R1: Sources map to pending bits as follows. Bit 0 is slot 1 trigger (`evt_i[0]`), bit 1 is slot 1 end of acquisition (`evt_i[1]`), bit 2 is slot 2 trigger (`evt_i[2]`) and bit 3 is slot 2 end of acquisition (`evt_i[3]`). A rising edge on a source sets its pending bit one clock later.
- R2: A source that stays high does not set its pending bit again after a clear. The source must first go low and rise again.
- R3: The word address selects the register: 0 is turn-off, 1 is turn-on, 2 is mask and 3 is pending. Read data appears together with the acknowledge.
- R4: In a turn-on write, each 1 bit sets the matching mask bit. In a turn-off write, each 1 bit clears the matching mask bit. Zero bits leave the mask unchanged. Words 0 and 1 read as zero.
- R5: The mask is all zeros after reset. Writes to word 2 do not change it.
- R6: Writing 1 to a pending bit clears it. If a rising edge on that source arrives in the same cycle as the clear, the bit stays set.
- R7: Pending bits latch whatever the mask holds. `irq_o` is high exactly while some bit is both pending and enabled, so an event that arrived while masked raises `irq_o` as soon as its source is turned on.
- R8: Bits 31 to 4 of every word read as zero, and writes to them have no effect.
- R9: A cycle with `bus_cyc_i` and `bus_stb_i` both high is acknowledged in the next cycle. Back-to-back strobes are acknowledged back to back. `bus_stall_o`, `bus_err_o` and `bus_rty_o` stay low.
- R10: A write changes a register bit only when the byte select that covers it is set. Bits 3:0 are covered by `bus_sel_i[0]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_cyc_i | input | 1 | Bus cycle in progress |
| bus_stb_i | input | 1 | Access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_adr_i | input | 2 | Word address (byte address bits 3:2) |
| bus_sel_i | input | 4 | Byte selects for writes |
| bus_dat_i | input | 32 | Write data |
| bus_dat_o | output | 32 | Read data, valid with acknowledge |
| bus_ack_o | output | 1 | Acknowledge, one cycle after strobe |
| bus_stall_o | output | 1 | Stall, always low |
| bus_err_o | output | 1 | Error response, always low |
| bus_rty_o | output | 1 | Retry response, always low |
| evt_i | input | 4 | Event lines, rising-edge sensitive |
| irq_o | output | 1 | Level interrupt request |

## Verification
The assertions assume that event lines and bus inputs are synchronous to `clk_i` and stable at each rising edge. They also assume that every event line is low while reset is held, so the first sample after reset cannot fake an edge. The stimulus meets these assumptions as follows:
- It changes every input only on the falling clock edge.
- It holds all event lines low through reset.
- It drives bus accesses one per cycle with the cycle and strobe signals raised together.

The bench reference model follows the same sampling convention. It is compared with `irq_o`, the acknowledge and the read data on every clock.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
  localparam int unsigned HUB_SRC_N  = 4;
  localparam int unsigned HUB_DATA_W = 32;
  localparam int unsigned HUB_ADR_W  = 2;

  typedef enum logic [HUB_ADR_W-1:0] {
    WORD_OFF  = 2'd0,
    WORD_ON   = 2'd1,
    WORD_MASK = 2'd2,
    WORD_PEND = 2'd3
  } hub_word_e;
endpackage

// File: rtl/irq_hub_edge.sv
module irq_hub_edge #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] evt_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] evt_q;

  for (genvar k = 0; k < N; k++) begin : g_src
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) evt_q[k] <= 1'b0;
      else         evt_q[k] <= evt_i[k];
    end
    assign rise_o[k] = evt_i[k] & ~evt_q[k];
  end
endmodule

// File: rtl/irq_hub_bus.sv
module irq_hub_bus
  import irq_hub_pkg::*;
#(
  parameter int unsigned N      = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_cyc_i,
  input  logic              bus_stb_i,
  input  logic              bus_we_i,
  input  logic [1:0]        bus_adr_i,
  input  logic [DATA_W/8-1:0] bus_sel_i,
  input  logic [DATA_W-1:0] bus_dat_i,
  output logic [DATA_W-1:0] bus_dat_o,
  output logic              bus_ack_o,
  input  logic [N-1:0]      pend_i,
  output logic [N-1:0]      mask_o,
  output logic [N-1:0]      clr_o
);
  localparam int unsigned PAD_W = DATA_W - N;

  logic         acc, wr;
  logic [N-1:0] wbits;
  hub_word_e    word;

  assign acc  = bus_cyc_i & bus_stb_i;
  assign wr   = acc & bus_we_i;
  assign word = hub_word_e'(bus_adr_i);

  for (genvar k = 0; k < N; k++) begin : g_wbit
    assign wbits[k] = bus_dat_i[k] & bus_sel_i[k/8];
  end

  assign clr_o = (wr && word == WORD_PEND) ? wbits : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_o <= '0;
    end else if (wr) begin
      case (word)
        WORD_ON:  mask_o <= mask_o | wbits;
        WORD_OFF: mask_o <= mask_o & ~wbits;
        default:  mask_o <= mask_o;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_ack_o <= 1'b0;
      bus_dat_o <= '0;
    end else begin
      bus_ack_o <= acc;
      if (acc && !bus_we_i) begin
        case (word)
          WORD_MASK: bus_dat_o <= {{PAD_W{1'b0}}, mask_o};
          WORD_PEND: bus_dat_o <= {{PAD_W{1'b0}}, pend_i};
          default:   bus_dat_o <= '0;
        endcase
      end
    end
  end

  a_r9_ack_after_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_ack_o |-> $past(bus_cyc_i && bus_stb_i));

  a_r8_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_ack_o |-> (bus_dat_o[DATA_W-1:N] == '0));

  a_r4_wo_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_ack_o && $past(!bus_we_i && bus_adr_i[1] == 1'b0)) |-> (bus_dat_o == '0));

  a_r5_mask_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr && (word == WORD_ON || word == WORD_OFF)) |=> $stable(mask_o));
endmodule

// File: rtl/irq_hub_pend.sv
module irq_hub_pend #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] rise_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] mask_i,
  output logic [N-1:0] pend_o,
  output logic         irq_o
);
  for (genvar k = 0; k < N; k++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        pend_o[k] <= 1'b0;
      else if (rise_i[k]) pend_o[k] <= 1'b1;
      else if (clr_i[k])  pend_o[k] <= 1'b0;
    end

    a_r1_edge_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_i[k] |=> pend_o[k]);

    a_r6_clear_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[k] && !rise_i[k]) |=> !pend_o[k]);

    a_r6_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend_o[k] && !clr_i[k]) |=> pend_o[k]);
  end

  assign irq_o = |(pend_o & mask_i);

  a_r7_irq_needs_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (pend_o != '0) && (mask_i != '0));
endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_hub_pkg::*;
#(
  parameter int unsigned SRC_N  = HUB_SRC_N,
  parameter int unsigned DATA_W = HUB_DATA_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bus_cyc_i,
  input  logic                bus_stb_i,
  input  logic                bus_we_i,
  input  logic [1:0]          bus_adr_i,
  input  logic [DATA_W/8-1:0] bus_sel_i,
  input  logic [DATA_W-1:0]   bus_dat_i,
  output logic [DATA_W-1:0]   bus_dat_o,
  output logic                bus_ack_o,
  output logic                bus_stall_o,
  output logic                bus_err_o,
  output logic                bus_rty_o,
  input  logic [SRC_N-1:0]    evt_i,
  output logic                irq_o
);
  logic [SRC_N-1:0] rise, clr, mask, pend;

  assign bus_stall_o = 1'b0;
  assign bus_err_o   = 1'b0;
  assign bus_rty_o   = 1'b0;

  irq_hub_edge #(.N(SRC_N)) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .evt_i (evt_i),
    .rise_o(rise)
  );

  irq_hub_bus #(.N(SRC_N), .DATA_W(DATA_W)) u_bus (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bus_cyc_i(bus_cyc_i),
    .bus_stb_i(bus_stb_i),
    .bus_we_i (bus_we_i),
    .bus_adr_i(bus_adr_i),
    .bus_sel_i(bus_sel_i),
    .bus_dat_i(bus_dat_i),
    .bus_dat_o(bus_dat_o),
    .bus_ack_o(bus_ack_o),
    .pend_i   (pend),
    .mask_o   (mask),
    .clr_o    (clr)
  );

  irq_hub_pend #(.N(SRC_N)) u_pend (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rise_i(rise),
    .clr_i (clr),
    .mask_i(mask),
    .pend_o(pend),
    .irq_o (irq_o)
  );
endmodule

// File: tb/irq_hub_test.sv
module irq_hub_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cyc = 1'b0, stb = 1'b0, we = 1'b0;
  logic [1:0]  adr = '0;
  logic [3:0]  sel = '0;
  logic [31:0] wdat = '0;
  logic [31:0] rdat;
  logic        ack, stall, err, rty, irq;
  logic [3:0]  evt = '0;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  irq_hub uut (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_cyc_i(cyc), .bus_stb_i(stb), .bus_we_i(we), .bus_adr_i(adr),
    .bus_sel_i(sel), .bus_dat_i(wdat), .bus_dat_o(rdat), .bus_ack_o(ack),
    .bus_stall_o(stall), .bus_err_o(err), .bus_rty_o(rty),
    .evt_i(evt), .irq_o(irq)
  );

  // Behavioural reference model
  logic [3:0]  m_mask, m_pend, m_prev;
  logic        m_ack, m_rd;
  logic [31:0] m_dat;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mask <= '0; m_pend <= '0; m_prev <= '0;
      m_ack <= 1'b0; m_rd <= 1'b0; m_dat <= '0;
    end else begin
      logic [3:0] edges, ones;
      edges = evt & ~m_prev;
      ones  = (cyc && stb && we && sel[0]) ? wdat[3:0] : 4'h0;
      m_ack <= cyc && stb;
      m_rd  <= cyc && stb && !we;
      if (cyc && stb && !we)
        m_dat <= (adr == 2'd2) ? {28'h0, m_mask} :
                 (adr == 2'd3) ? {28'h0, m_pend} : 32'h0;
      if (adr == 2'd1) m_mask <= m_mask | ones;
      else if (adr == 2'd0) m_mask <= m_mask & ~ones;
      m_pend <= (m_pend & ~((adr == 2'd3) ? ones : 4'h0)) | edges;
      m_prev <= evt;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      check(irq === |(m_pend & m_mask), "R7 irq level", {31'h0, irq}, {31'h0, |(m_pend & m_mask)});
      check(ack === m_ack, "R9 ack timing", {31'h0, ack}, {31'h0, m_ack});
      check({stall, err, rty} === 3'b000, "R9 stall/err/rty low", {29'h0, stall, err, rty}, 32'h0);
      if (m_ack && m_rd) check(rdat === m_dat, "R3 read data", rdat, m_dat);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic [3:0] s);
    @(negedge clk);
    cyc = 1'b1; stb = 1'b1; we = 1'b1; adr = a; wdat = d; sel = s;
    @(negedge clk);
    cyc = 1'b0; stb = 1'b0; we = 1'b0; sel = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    cyc = 1'b1; stb = 1'b1; we = 1'b0; adr = a;
    @(negedge clk);
    cyc = 1'b0; stb = 1'b0;
    d = rdat;
  endtask

  task automatic pulse(input int k);
    @(negedge clk); evt[k] = 1'b1;
    @(negedge clk); evt[k] = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual 0x1 expected 0x0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // reset state
    rd(2'd2, v); check(v == 32'h0, "R5 mask after reset", v, 32'h0);
    rd(2'd3, v); check(v == 32'h0, "R6 pending after reset", v, 32'h0);
    check(irq == 1'b0, "R7 irq after reset", {31'h0, irq}, 32'h0);

    // mapping and latch while masked
    for (int k = 0; k < 4; k++) begin
      pulse(k);
      rd(2'd3, v); check(v == (32'h1 << k), "R1 source bit map", v, 32'h1 << k);
      check(irq == 1'b0, "R7 masked pending no irq", {31'h0, irq}, 32'h0);
      wr(2'd3, 32'hF, 4'hF);
    end

    pulse(0);
    wr(2'd1, 32'h1, 4'hF);
    @(negedge clk);
    check(irq == 1'b1, "R7 pending raises irq when enabled", {31'h0, irq}, 32'h1);
    rd(2'd2, v); check(v == 32'h1, "R4 enable sets mask", v, 32'h1);
    wr(2'd3, 32'h1, 4'hF);
    rd(2'd3, v); check(v == 32'h0, "R6 write-one clears", v, 32'h0);
    check(irq == 1'b0, "R7 irq drops after clear", {31'h0, irq}, 32'h0);

    // held-high source
    @(negedge clk); evt[2] = 1'b1;
    repeat (3) @(negedge clk);
    rd(2'd3, v); check(v == 32'h4, "R2 held source latched", v, 32'h4);
    wr(2'd3, 32'h4, 4'hF);
    repeat (3) @(negedge clk);
    rd(2'd3, v); check(v == 32'h0, "R2 held source no relatch", v, 32'h0);
    evt[2] = 1'b0;
    pulse(2);
    rd(2'd3, v); check(v == 32'h4, "R2 new edge relatches", v, 32'h4);
    wr(2'd3, 32'h4, 4'hF);

    // edge beats simultaneous clear
    pulse(3);
    @(negedge clk);
    cyc = 1'b1; stb = 1'b1; we = 1'b1; adr = 2'd3; wdat = 32'h8; sel = 4'hF; evt[3] = 1'b1;
    @(negedge clk);
    cyc = 1'b0; stb = 1'b0; we = 1'b0; evt[3] = 1'b0;
    rd(2'd3, v); check(v == 32'h8, "R6 edge wins over clear", v, 32'h8);

    // mask handling
    wr(2'd2, 32'hF, 4'hF);
    rd(2'd2, v); check(v == 32'h1, "R5 mask read-only", v, 32'h1);
    wr(2'd1, 32'hFFFF_FFFF, 4'hF);
    rd(2'd2, v); check(v == 32'hF, "R8 upper bits ignored", v, 32'hF);
    wr(2'd1, 32'h0, 4'hF);
    rd(2'd2, v); check(v == 32'hF, "R4 zeros leave mask", v, 32'hF);
    wr(2'd0, 32'h5, 4'hF);
    rd(2'd2, v); check(v == 32'hA, "R4 disable clears mask", v, 32'hA);
    rd(2'd0, v); check(v == 32'h0, "R4 disable reads zero", v, 32'h0);
    rd(2'd1, v); check(v == 32'h0, "R4 enable reads zero", v, 32'h0);
    wr(2'd1, 32'h1, 4'hE);
    rd(2'd2, v); check(v == 32'hA, "R10 byte select gates write", v, 32'hA);
    wr(2'd3, 32'hF, 4'hE);
    rd(2'd3, v); check(v == 32'h8, "R10 clear needs byte select", v, 32'h8);
    check(irq == 1'b1, "R7 bit3 enabled and pending", {31'h0, irq}, 32'h1);

    // back-to-back pipelined reads
    @(negedge clk);
    cyc = 1'b1; stb = 1'b1; we = 1'b0; adr = 2'd2;
    @(negedge clk);
    adr = 2'd3;
    check(ack == 1'b1 && rdat == 32'hA, "R9 first pipelined ack", rdat, 32'hA);
    @(negedge clk);
    cyc = 1'b0; stb = 1'b0;
    check(ack == 1'b1 && rdat == 32'h8, "R9 second pipelined ack", rdat, 32'h8);
    @(negedge clk);
    check(ack == 1'b0, "R9 ack drops", {31'h0, ack}, 32'h0);

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule